// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Instruction Sequencer

This block is a small processor core with no register file. Each instruction names two source words and one destination word in a single shared RAM that holds both program and data. A state machine takes every arithmetic or logic instruction through the same steps. It fetches the instruction word, reads the first source, reads the second source, computes the result, writes it back to the destination and moves the program counter on.

Relative jumps, taken always or only when a condition holds, skip the operand reads, the execute step and the write-back. A conditional jump tests the sign or zero indication stored by the last instruction that wrote memory. A halt instruction stops the sequencer and raises a status pin.

The RAM sits outside the core. It is single-ported and synchronous, with one cycle of read latency. The core drives its address, write enable and write data, and receives its read data one cycle after the address.

Top module: `tcyc_core`

## Requirements
- R1: While reset is high and at the first cycle after it is released, the core drives address 0, write enable low and halt low. The program counter and both flag sets are cleared, so a conditional jump before any write-back is not taken.
- R2: An instruction is fetched with one read at the program counter. The word is laid out as opcode in bits 27:24, source A in bits 23:16, source B in bits 15:8 and destination C in bits 7:0.
- R3: An arithmetic or logic instruction reads the word at A, then the word at B, both using bits 15:0. It writes the 16-bit result, zero-extended to 28 bits, to address C.
- R4: The opcode values are 0 add, 1 subtract (A minus B), 2 bitwise and, 3 bitwise or, 4 jump, 5 jump if negative, 6 jump if zero and 7 halt. The values 8 to 15 behave as halt.
- R5: Add and subtract wrap modulo 2^16.
- R6: The negative flag is bit 15 of the result and the zero flag marks a zero result. The jump conditions see these flags only after the instruction's write-back.
- R7: A non-jump instruction takes 7 cycles and advances the program counter by one.
- R8: A jump adds field C, read as an 8-bit two's-complement offset, to its own address. It writes no memory and takes 3 cycles.
- R9: A conditional jump that is not taken advances the program counter by one in 3 cycles.
- R10: Jumps do not change the flags, so consecutive conditional jumps test the same flags.
- R11: After a halt instruction the halt pin stays high and the core never writes memory again until reset.
- R12: The program counter wraps modulo 256, both on sequential advance and on a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | RAM address for the current read or write |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 28 | RAM write data (result, zero-extended) |
| mem_rdata | input | 28 | RAM read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench times whole programs from reset release to halt, so a core that spends an extra cycle in any step, or that skips or adds a step for jumps, ends with the wrong cycle count. One program runs a conditional jump right after a zero result, then a second conditional jump that must see the same flags. A core that updates flags at execute time or clears them on a jump takes a different path and lands on a trap halt. Negative offsets, a result that wraps past 0xFFFF and a program counter that wraps from 255 to 0 are each exercised. Checks on the RAM contents would catch operands taken from the wrong field, or high bits left set in the write data. Opcodes above 7 must halt, and writes after halt are watched for.

// File: rtl/tcyc_pkg.sv
package tcyc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int OPC_W  = 4;
    localparam int WORD_W = OPC_W + 3 * ADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_BR   = 4'd4,
        OP_BRN  = 4'd5,
        OP_BRZ  = 4'd6,
        OP_HALT = 4'd7
    } opcode_e;

    typedef struct packed {
        opcode_e           op;
        logic [ADDR_W-1:0] src_a;
        logic [ADDR_W-1:0] src_b;
        logic [ADDR_W-1:0] dst_c;
    } instr_t;

    typedef struct packed {
        logic neg;
        logic zero;
    } flags_t;

    typedef enum logic [2:0] {
        S_FETCH,
        S_LOAD,
        S_DECODE,
        S_RDA,
        S_RDB,
        S_EXEC,
        S_WRITE,
        S_STOP
    } state_e;

    function automatic logic is_jump(opcode_e op);
        return (op == OP_BR) || (op == OP_BRN) || (op == OP_BRZ);
    endfunction

    function automatic logic is_stop(opcode_e op);
        return logic'(op >= OP_HALT);
    endfunction

endpackage

// File: rtl/tcyc_alu.sv
module tcyc_alu
    import tcyc_pkg::*;
(
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output flags_t            f
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = '0;
        endcase
        f.neg  = y[DATA_W-1];
        f.zero = (y == '0);
    end
endmodule

// File: rtl/tcyc_jump.sv
module tcyc_jump
    import tcyc_pkg::*;
(
    input  opcode_e op,
    input  flags_t  flags,
    output logic    take
);
    always_comb begin
        unique case (op)
            OP_BR:   take = 1'b1;
            OP_BRN:  take = flags.neg;
            OP_BRZ:  take = flags.zero;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcyc_core.sv
module tcyc_core
    import tcyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    state_e            state;
    logic [ADDR_W-1:0] pc;
    instr_t            ir;
    logic [DATA_W-1:0] opa, opb, res;
    flags_t            aflags, mflags;

    logic [DATA_W-1:0] alu_y;
    flags_t            alu_f;
    logic              take;

    tcyc_alu u_alu (.op(ir.op), .a(opa), .b(opb), .y(alu_y), .f(alu_f));
    tcyc_jump u_jump (.op(ir.op), .flags(mflags), .take(take));

    // Address steering: each read is issued one state before its data is captured.
    always_comb begin
        unique case (state)
            S_DECODE: mem_addr = ir.src_a;
            S_RDA:    mem_addr = ir.src_b;
            S_WRITE:  mem_addr = ir.dst_c;
            default:  mem_addr = pc;
        endcase
        mem_we    = (state == S_WRITE);
        mem_wdata = {{(WORD_W-DATA_W){1'b0}}, res};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_FETCH;
            pc     <= '0;
            ir     <= '0;
            opa    <= '0;
            opb    <= '0;
            res    <= '0;
            aflags <= '0;
            mflags <= '0;
            halted <= 1'b0;
        end else begin
            unique case (state)
                S_FETCH: state <= S_LOAD;
                S_LOAD: begin
                    ir    <= instr_t'(mem_rdata);
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    if (is_stop(ir.op)) begin
                        halted <= 1'b1;
                        state  <= S_STOP;
                    end else if (is_jump(ir.op)) begin
                        pc    <= take ? pc + ir.dst_c : pc + 1'b1;
                        state <= S_FETCH;
                    end else begin
                        state <= S_RDA;
                    end
                end
                S_RDA: begin
                    opa   <= mem_rdata[DATA_W-1:0];
                    state <= S_RDB;
                end
                S_RDB: begin
                    opb   <= mem_rdata[DATA_W-1:0];
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    res    <= alu_y;
                    aflags <= alu_f;
                    state  <= S_WRITE;
                end
                S_WRITE: begin
                    mflags <= aflags;
                    pc     <= pc + 1'b1;
                    state  <= S_FETCH;
                end
                default: state <= S_STOP;
            endcase
        end
    end

    assert_fetch_at_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |-> (mem_addr == pc && !mem_we));

    assert_seq_step_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITE) |=> (pc == $past(pc) + 1'b1));

    assert_jump_offset_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && ir.op == OP_BR) |=> (pc == $past(pc) + $past(ir.dst_c)));

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state != S_WRITE) |=> $stable(mflags));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_we));

endmodule

// File: tb/tb_tcyc_core.sv
module tb_tcyc_core;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [27:0] mem_wdata;
    logic [27:0] mem_rdata;
    logic        halted;

    logic [27:0] ram [256];
    int checks = 0;
    int errors = 0;
    int total_cyc = 0;

    always #2.5 clk = ~clk;

    tcyc_core dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
                   .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted));

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
        total_cyc <= total_cyc + 1;
    end

    // op, operand A value, operand B value, expected result
    localparam logic [51:0] VEC [0:5] = '{
        {4'd0, 16'd3,     16'd4,     16'd7},
        {4'd0, 16'hFFFF,  16'h0001,  16'h0000},
        {4'd1, 16'd5,     16'd7,     16'hFFFE},
        {4'd2, 16'hF0F0,  16'h3C3C,  16'h3030},
        {4'd3, 16'hF000,  16'h000F,  16'hF00F},
        {4'd1, 16'h8000,  16'h0001,  16'h7FFF}
    };

    function automatic logic [27:0] enc(int op, int a, int b, int c);
        return {op[3:0], a[7:0], b[7:0], c[7:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_ram();
        for (int i = 0; i < 256; i++) ram[i] = '0;
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk); #1;
            cyc++;
        end while (!halted && cyc < 1000);
    endtask

    initial begin
        if (0) ;
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int wr;
        rst = 1'b1;

        // R1: reset state
        clear_ram();
        ram[0] = enc(7, 0, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 addr in reset", 32'(mem_addr), 0);
        check("R1 we/halt in reset", {30'd0, mem_we, halted}, 0);
        rst = 1'b0;
        check("R1 addr after release", 32'(mem_addr), 0);

        // Table of ALU vectors, one instruction each (R3, R4, R5, R7)
        clear_ram();
        for (int i = 0; i < 6; i++) begin
            ram[100 + 2*i] = 28'(VEC[i][47:32]);
            ram[101 + 2*i] = 28'(VEC[i][31:16]);
            ram[i] = enc(int'(VEC[i][51:48]), 100 + 2*i, 101 + 2*i, 200 + i);
        end
        ram[6] = enc(7, 0, 0, 0);
        start();
        run(cyc);
        for (int i = 0; i < 6; i++)
            check("R3 R5 alu result at C", 32'(ram[200 + i]), 32'(VEC[i][15:0]));
        check("R7 six ops plus halt cycles", cyc, 45);
        check("R11 halted", 32'(halted), 1);

        // R11: no writes after halt
        wr = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_we) wr++;
        end
        check("R11 writes after halt", wr, 0);
        check("R11 halt stays high", 32'(halted), 1);

        // Jumps: flags from write-back, taken/not taken, negative offset (R6, R8, R9, R10)
        clear_ram();
        ram[100] = 28'd5; ram[101] = 28'd5; ram[104] = 28'd0; ram[105] = 28'd1;
        ram[0]  = enc(1, 100, 101, 102);   // 0 -> zero
        ram[1]  = enc(5, 0, 0, 5);         // BRN not taken
        ram[2]  = enc(6, 0, 0, 2);         // BRZ taken -> 4
        ram[3]  = enc(7, 0, 0, 0);         // trap
        ram[4]  = enc(6, 0, 0, 2);         // BRZ same flags -> 6
        ram[5]  = enc(7, 0, 0, 0);         // trap
        ram[6]  = enc(4, 0, 0, 3);         // BR -> 9
        ram[7]  = enc(0, 100, 101, 107);   // 10
        ram[8]  = enc(7, 0, 0, 0);
        ram[9]  = enc(1, 104, 105, 106);   // 0xFFFF, negative
        ram[10] = enc(5, 0, 0, 8'hFD);     // BRN -3 -> 7
        ram[11] = enc(7, 0, 0, 0);         // trap
        start();
        run(cyc);
        check("R6 zero result stored", 32'(ram[102]), 0);
        check("R5 wrap to FFFF", 32'(ram[106]), 32'h0000FFFF);
        check("R8 negative offset path reached", 32'(ram[107]), 10);
        check("R9 R10 jump path cycles", cyc, 39);

        // Wrap of the program counter (R12) and cleared flags after reset (R1)
        clear_ram();
        ram[104] = 28'd0; ram[105] = 28'd1;
        ram[0]   = enc(5, 0, 0, 2);        // not taken first time, taken second
        ram[1]   = enc(4, 0, 0, 8'hFE);    // -> 255
        ram[255] = enc(1, 104, 105, 102);  // negative, pc wraps to 0
        ram[2]   = enc(7, 0, 0, 0);
        start();
        run(cyc);
        check("R12 instruction at 255 ran", 32'(ram[102]), 32'h0000FFFF);
        check("R12 R1 wrap path cycles", cyc, 19);

        // R4: undefined opcode halts
        clear_ram();
        ram[0] = enc(15, 0, 0, 0);
        ram[1] = enc(0, 0, 0, 50);
        start();
        run(cyc);
        check("R4 opcode 15 halts", cyc, 3);

        // R2: fetch issues pc; write data zero-extended (R3)
        clear_ram();
        ram[3] = 28'hFFFFFFF; ram[4] = 28'h0000001;
        ram[0] = enc(0, 3, 4, 9);
        ram[1] = enc(7, 0, 0, 0);
        start();
        check("R2 first fetch address", 32'(mem_addr), 0);
        run(cyc);
        check("R3 upper bits zero", 32'(ram[9]), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule